// File: doc/BRIEF.md
# Receive Ring Packet Reader

This block drains one packet at a time from a circular receive buffer held in an external byte-wide memory. A pulse on `start` asks for the oldest buffered packet. If the buffered-packet count is zero, the block answers at once with a zero length and leaves the memory untouched. Otherwise it walks the packet's receive header, jumps to the sender's address and the 802.3 length field, and streams out the payload bytes, never more than the caller allows. It then gives the buffer space back by writing a read-pointer value and pulsing a count-decrement strobe.

Every address the block drives stays inside a fixed ring whose bounds are parameters; stepping past the last address continues at the first. The header's next-packet pointer becomes the start of the following read, so repeated requests consume the ring in order. Packet filtering and frame check sequences are handled elsewhere.

Top module: `rx_ring_reader`

## Requirements
- R1: After reset the block is idle: `busy`, `memRd`, `payValid`, `rdPtrWe`, `pktDec` and `done` are low, and the first packet is read from the ring start.
- R2: A `start` taken while idle with `pktCount` equal to zero raises `done` on the next cycle with `payLen` 0, and issues no memory read, no pointer write and no `pktDec`.
- R3: A packet read begins with four consecutive reads from the current packet pointer: next-pointer low byte, next-pointer high byte, frame-length low byte, frame-length high byte (the two status bytes that follow are skipped).
- R4: The sender address is read next, six bytes starting at current+12; if that sum exceeds the ring end it is reduced by the ring size (end − start + 1). The first byte read appears in `srcMac[47:40]`.
- R5: Every step to the following address goes from the ring end to the ring start, so the length field is read at current+18 wrapped, high byte first.
- R6: A nonzero length high byte gives `payLen` 0; the low byte is then not read and no payload is streamed.
- R7: Otherwise `payLen` is the smallest of the length low byte, `maxLen` (sampled at `start`) and frame length − 14; a frame length of 14 or less gives 0.
- R8: Exactly `payLen` payload bytes are streamed in memory order, one per cycle, each marked by `payValid`.
- R9: After the payload, `rdPtrWe` pulses once with `rdPtr` = next − 1; when next − 1 falls below the ring start or above the ring end, the ring end is written instead.
- R10: The cycle after the pointer write, `pktDec` and `done` pulse together with the final `payLen`; the following request reads from the header's next pointer.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to read one packet |
| pktCount | input | CNT_W | Number of packets held in the ring |
| maxLen | input | LEN_W | Caller's payload limit |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 8 | Memory read data, valid in the same cycle |
| payValid | output | 1 | Payload byte valid |
| payData | output | 8 | Payload byte |
| srcMac | output | 48 | Sender address of the current packet |
| payLen | output | LEN_W | Payload length delivered |
| rdPtrWe | output | 1 | Read-pointer release write |
| rdPtr | output | ADDR_W | Read-pointer release value |
| pktDec | output | 1 | Packet-count decrement strobe |
| done | output | 1 | Request finished |
| busy | output | 1 | Request in progress |

## Verification
With `start` sampled at edge 0, an empty request shows `done` one cycle later; a full read spends four header cycles, six address cycles, one or two length cycles and one cycle per payload byte, then one pointer-write cycle and the `done`/`pktDec` cycle. Because the memory answers in the same cycle, payload bytes, the pointer write and `done` are all combinational decodes of the state register, so the monitor samples every strobe on the falling edge of the cycle it belongs to and compares it against the queued expectations in order rather than at fixed offsets. The read addresses are logged per request to check header, sender and length positions across the ring wrap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_BYTES = 4;   // next pointer + frame length
  localparam int MAC_BYTES = 6;
  localparam int SRC_OFS   = 12;  // status bytes + destination address
  localparam int ETH_HDR   = 14;  // addresses + length field

  typedef struct packed {
    logic latch;   // new request: sample limit, clear length
    logic toCur;   // address := current packet pointer
    logic toMac;   // address := sender address position
    logic step;    // address := wrapped increment
    logic capHdr;  // shift header byte in
    logic capMac;  // shift sender byte in
    logic capLen;  // store computed payload length
    logic commit;  // current pointer := next pointer
  } rxr_strobe_t;
endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] pktCount,
  input  logic             lenHiBad,
  input  logic [LEN_W-1:0] lenCalc,
  input  logic [LEN_W-1:0] payLen,
  output rxr_strobe_t      stb,
  output logic             memRd,
  output logic             payValid,
  output logic             rdPtrWe,
  output logic             pktDec,
  output logic             done,
  output logic             busy
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_EMPTY, ST_HDR, ST_MAC, ST_LENH, ST_LENL, ST_PAY, ST_REL, ST_DEC
  } rxr_state_e;

  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] MAC_LAST = LEN_W'(MAC_BYTES - 1);

  rxr_state_e state, stateNxt;
  logic [LEN_W-1:0] cnt, cntNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    stb      = '0;
    memRd    = 1'b0;
    payValid = 1'b0;
    rdPtrWe  = 1'b0;
    pktDec   = 1'b0;
    done     = 1'b0;
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          if (pktCount == '0) begin
            stateNxt = ST_EMPTY;
          end else begin
            stb.toCur = 1'b1;
            cntNxt    = '0;
            stateNxt  = ST_HDR;
          end
        end
      end
      ST_EMPTY: begin
        done     = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_HDR: begin
        memRd      = 1'b1;
        stb.capHdr = 1'b1;
        if (cnt == HDR_LAST) begin
          stb.toMac = 1'b1;
          cntNxt    = '0;
          stateNxt  = ST_MAC;
        end else begin
          stb.step = 1'b1;
          cntNxt   = cnt + 1'b1;
        end
      end
      ST_MAC: begin
        memRd      = 1'b1;
        stb.capMac = 1'b1;
        stb.step   = 1'b1;
        if (cnt == MAC_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_LENH;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_LENH: begin
        memRd    = 1'b1;
        stb.step = 1'b1;
        stateNxt = lenHiBad ? ST_REL : ST_LENL;
      end
      ST_LENL: begin
        memRd      = 1'b1;
        stb.step   = 1'b1;
        stb.capLen = 1'b1;
        cntNxt     = '0;
        stateNxt   = (lenCalc == '0) ? ST_REL : ST_PAY;
      end
      ST_PAY: begin
        memRd    = 1'b1;
        payValid = 1'b1;
        stb.step = 1'b1;
        if (cnt == payLen - 1'b1) begin
          stateNxt = ST_REL;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_REL: begin
        rdPtrWe  = 1'b1;
        stateNxt = ST_DEC;
      end
      ST_DEC: begin
        pktDec     = 1'b1;
        done       = 1'b1;
        stb.commit = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rxr_dp.sv
module rxr_dp
  import rxr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int LEN_W      = 8,
  parameter int RING_START = 0,
  parameter int RING_END   = 'h19FD
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxr_strobe_t       stb,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        payData,
  output logic [47:0]       srcMac,
  output logic [LEN_W-1:0]  payLen,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              lenHiBad,
  output logic [LEN_W-1:0]  lenCalc
);
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(RING_START);
  localparam logic [ADDR_W-1:0] END_A   = ADDR_W'(RING_END);
  localparam logic [ADDR_W:0]   END_X   = (ADDR_W+1)'(RING_END);
  localparam logic [ADDR_W:0]   SIZE_X  = (ADDR_W+1)'(RING_END - RING_START + 1);
  localparam logic [ADDR_W:0]   OFS_X   = (ADDR_W+1)'(SRC_OFS);
  localparam logic [16:0]       START17 = 17'(RING_START);
  localparam logic [16:0]       END17   = 17'(RING_END);
  localparam logic [15:0]       HDR16   = 16'(ETH_HDR);

  logic [ADDR_W-1:0] addr, cur;
  logic [31:0]       hdr;    // {lenHi, lenLo, nextHi, nextLo}
  logic [47:0]       mac;
  logic [LEN_W-1:0]  maxLat, lenReg;

  logic [15:0]       nextPtr, frameLen, fromFrame;
  logic [ADDR_W:0]   macSum, macBase;
  logic [16:0]       nextM1;
  logic [LEN_W-1:0]  effMax;

  assign nextPtr  = hdr[15:0];
  assign frameLen = hdr[31:16];

  always_comb begin
    macSum  = {1'b0, cur} + OFS_X;
    macBase = (macSum > END_X) ? macSum - SIZE_X : macSum;
  end

  always_comb begin
    fromFrame = frameLen - HDR16;
    if (frameLen <= HDR16)               effMax = '0;
    else if (fromFrame < 16'(maxLat))    effMax = fromFrame[LEN_W-1:0];
    else                                 effMax = maxLat;
    lenCalc = (LEN_W'(memData) < effMax) ? LEN_W'(memData) : effMax;
  end

  always_comb begin
    nextM1 = {1'b0, nextPtr} - 17'd1;
    if (nextM1[16] || ({1'b0, nextPtr} <= START17) || (nextM1 > END17)) rdPtr = END_A;
    else                                                                rdPtr = nextM1[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr   <= START_A;
      cur    <= START_A;
      hdr    <= '0;
      mac    <= '0;
      maxLat <= '0;
      lenReg <= '0;
    end else begin
      if (stb.latch) begin
        maxLat <= maxLen;
        lenReg <= '0;
      end
      if (stb.toCur)      addr <= cur;
      else if (stb.toMac) addr <= macBase[ADDR_W-1:0];
      else if (stb.step)  addr <= (addr == END_A) ? START_A : addr + 1'b1;
      if (stb.capHdr) hdr <= {memData, hdr[31:8]};
      if (stb.capMac) mac <= {mac[39:0], memData};
      if (stb.capLen) lenReg <= lenCalc;
      if (stb.commit) cur <= nextPtr[ADDR_W-1:0];
    end
  end

  assign memAddr  = addr;
  assign payData  = memData;
  assign srcMac   = mac;
  assign payLen   = lenReg;
  assign lenHiBad = (memData != 8'd0);
endmodule

// File: rtl/rx_ring_reader.sv
module rx_ring_reader
  import rxr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int CNT_W      = 8,
  parameter int LEN_W      = 8,
  parameter int RING_START = 0,
  parameter int RING_END   = 'h19FD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  pktCount,
  input  logic [LEN_W-1:0]  maxLen,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              payValid,
  output logic [7:0]        payData,
  output logic [47:0]       srcMac,
  output logic [LEN_W-1:0]  payLen,
  output logic              rdPtrWe,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              pktDec,
  output logic              done,
  output logic              busy
);
  rxr_strobe_t      stb;
  logic             lenHiBad;
  logic [LEN_W-1:0] lenCalc;

  rxr_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .pktCount(pktCount),
    .lenHiBad(lenHiBad), .lenCalc(lenCalc), .payLen(payLen), .stb(stb),
    .memRd(memRd), .payValid(payValid), .rdPtrWe(rdPtrWe), .pktDec(pktDec),
    .done(done), .busy(busy)
  );

  rxr_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RING_START(RING_START), .RING_END(RING_END)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .maxLen(maxLen), .memData(memData),
    .memAddr(memAddr), .payData(payData), .srcMac(srcMac), .payLen(payLen),
    .rdPtr(rdPtr), .lenHiBad(lenHiBad), .lenCalc(lenCalc)
  );
endmodule

// File: rtl/rx_ring_reader_chk.sv
module rx_ring_reader_chk #(
  parameter int ADDR_W     = 13,
  parameter int CNT_W      = 8,
  parameter int LEN_W      = 8,
  parameter int RING_START = 0,
  parameter int RING_END   = 'h19FD
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  pktCount,
  input logic [LEN_W-1:0]  maxLen,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              payValid,
  input logic [LEN_W-1:0]  payLen,
  input logic              rdPtrWe,
  input logic [ADDR_W-1:0] rdPtr,
  input logic              pktDec,
  input logic              done,
  input logic              busy
);
  localparam logic [ADDR_W-1:0] END_A   = ADDR_W'(RING_END);
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(RING_START);

  logic [LEN_W:0]   payCnt;
  logic [LEN_W-1:0] maxSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payCnt  <= '0;
      maxSeen <= '0;
    end else if (start && !busy) begin
      payCnt  <= '0;
      maxSeen <= maxLen;
    end else if (payValid) begin
      payCnt <= payCnt + 1'b1;
    end
  end

  // R2
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && pktCount == '0) |=> (done && payLen == '0 && !memRd && !pktDec && !rdPtrWe));

  // R5
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr <= END_A && memAddr >= START_A));

  // R9
  release_in_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPtrWe |-> (rdPtr <= END_A && rdPtr >= START_A));

  // R10
  dec_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktDec |-> ($past(rdPtrWe) && done));

  // R8
  payload_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (payCnt == {1'b0, payLen}));

  // R7
  length_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (payLen <= maxSeen));
endmodule

bind rx_ring_reader rx_ring_reader_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
  .RING_START(RING_START), .RING_END(RING_END)
) chk_i (.*);

// File: tb/rx_ring_reader_tb_top.sv
module rx_ring_reader_tb_top;
  localparam int RING_END = 'h19FD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pktCount = '0;
  logic [7:0]  maxLen = '0;
  logic        memRd, payValid, rdPtrWe, pktDec, done, busy;
  logic [12:0] memAddr, rdPtr;
  logic [7:0]  memData, payData, payLen;
  logic [47:0] srcMac;

  logic [7:0] mem [0:8191];

  always #10 clk = ~clk;

  assign memData = mem[memAddr];

  rx_ring_reader dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pktCount(pktCount), .maxLen(maxLen),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .payValid(payValid),
    .payData(payData), .srcMac(srcMac), .payLen(payLen), .rdPtrWe(rdPtrWe),
    .rdPtr(rdPtr), .pktDec(pktDec), .done(done), .busy(busy)
  );

  int nChk = 0, nFail = 0;
  logic [7:0]  expQ[$];
  int          rdLog[$];
  logic [7:0]  expLen;
  logic [47:0] expMac;
  logic [12:0] expRd;
  bit          expEmpty;
  bit          doneSeen;
  int          relCnt, decCnt, doneCnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wrapAdd(input int a, input int n);
    int r = a;
    for (int i = 0; i < n; i++) r = (r == RING_END) ? 0 : r + 1;
    return r;
  endfunction

  // scoreboard monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd) rdLog.push_back(int'(memAddr));
      if (payValid) begin
        if (expQ.size() == 0) chk(1'b0, "R8", "unexpected payload byte", payData, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(payData == e, "R8", "payload byte", payData, e);
        end
      end
      if (rdPtrWe) begin
        relCnt++;
        chk(rdPtr == expRd, "R9", "release pointer", rdPtr, expRd);
      end
      if (pktDec) decCnt++;
      if (done) begin
        doneCnt++;
        chk(payLen == expLen, "R7", "payload length", payLen, expLen);
        chk(pktDec == !expEmpty, "R10", "decrement with done", pktDec, !expEmpty);
        if (!expEmpty) chk(srcMac == expMac, "R4", "sender address", srcMac, expMac);
        doneSeen = 1'b1;
      end
    end
  end

  task automatic fire(input int cnt, input int maxL, input bit extraStart);
    @(negedge clk);
    doneSeen = 1'b0; relCnt = 0; decCnt = 0; doneCnt = 0;
    rdLog.delete();
    pktCount = 8'(cnt); maxLen = 8'(maxL); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extraStart) begin
      repeat (4) @(negedge clk);
      pktCount = 8'd0; start = 1'b1;   // R11: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && !doneSeen; i++) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(doneCnt == 1, "R11", "done pulses per request", doneCnt, 1);
    chk(busy == 1'b0, "R11", "idle after request", busy, 0);
    chk(expQ.size() == 0, "R8", "payload bytes left over", expQ.size(), 0);
  endtask

  task automatic runEmpty();
    expEmpty = 1'b1; expLen = 8'd0;
    fire(0, 200, 1'b0);
    chk(rdLog.size() == 0, "R2", "memory reads on empty", rdLog.size(), 0);
    chk(relCnt == 0, "R2", "release on empty", relCnt, 0);
    chk(decCnt == 0, "R2", "decrement on empty", decCnt, 0);
  endtask

  task automatic runPkt(input int cur, input int next, input int frameLen,
                        input logic [47:0] mac, input int hi, input int lo,
                        input int maxL, input int seed, input bit extraStart);
    int a, eff, len, lenAddr;
    mem[wrapAdd(cur, 0)] = 8'(next);
    mem[wrapAdd(cur, 1)] = 8'(next >> 8);
    mem[wrapAdd(cur, 2)] = 8'(frameLen);
    mem[wrapAdd(cur, 3)] = 8'(frameLen >> 8);
    mem[wrapAdd(cur, 4)] = 8'hA5;
    mem[wrapAdd(cur, 5)] = 8'h5A;
    for (int i = 0; i < 6; i++) mem[wrapAdd(cur, 12 + i)] = mac[47 - 8*i -: 8];
    lenAddr = wrapAdd(cur, 18);
    mem[lenAddr] = 8'(hi);
    mem[wrapAdd(lenAddr, 1)] = 8'(lo);
    a = wrapAdd(lenAddr, 2);
    for (int i = 0; i < lo; i++) begin
      mem[a] = 8'(seed + 7*i);
      a = wrapAdd(a, 1);
    end
    eff = (frameLen <= 14) ? 0 : ((frameLen - 14 < maxL) ? frameLen - 14 : maxL);
    len = (hi != 0) ? 0 : ((lo < eff) ? lo : eff);
    expQ.delete();
    for (int i = 0; i < len; i++) expQ.push_back(8'(seed + 7*i));
    expEmpty = 1'b0; expLen = 8'(len); expMac = mac;
    expRd = (next == 0 || next - 1 > RING_END) ? 13'(RING_END) : 13'(next - 1);
    fire(3, maxL, extraStart);
    chk(relCnt == 1, "R9", "release writes", relCnt, 1);
    chk(decCnt == 1, "R10", "decrement pulses", decCnt, 1);
    chk(rdLog.size() == ((hi != 0) ? 11 : 12 + len), "R6", "read count", rdLog.size(),
        (hi != 0) ? 11 : 12 + len);
    if (rdLog.size() >= 11) begin
      for (int i = 0; i < 4; i++)
        chk(rdLog[i] == wrapAdd(cur, i), "R3", "header address", rdLog[i], wrapAdd(cur, i));
      chk(rdLog[4] == wrapAdd(cur, 12), "R4", "sender address start", rdLog[4], wrapAdd(cur, 12));
      chk(rdLog[10] == lenAddr, "R5", "length field address", rdLog[10], lenAddr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memRd && !payValid, "R1", "idle strobes", {busy, memRd, payValid}, 0);
    chk(!rdPtrWe && !pktDec && !done, "R1", "idle release", {rdPtrWe, pktDec, done}, 0);

    runEmpty();                                                                        // R2
    runPkt('h0000, 'h0040, 34, 48'h0211_2233_4455, 0, 10, 255, 'h10, 1'b1);           // R1 start, R11
    runPkt('h0040, 'h0100, 60, 48'h0A0B_0C0D_0E0F, 0, 30, 5, 'h20, 1'b0);              // R7 maxLen cap
    runPkt('h0100, 'h19F0, 17, 48'h1111_2222_3333, 0, 50, 200, 'h30, 1'b0);            // R7 frame cap
    runPkt('h19F0, 'h0000, 100, 48'hDEAD_BEEF_0001, 1, 9, 255, 'h40, 1'b0);            // R6, R4 wrap, R9 low clamp
    runPkt('h0000, 'h0200, 10, 48'h0102_0304_0506, 0, 8, 100, 'h50, 1'b0);             // R7 short frame
    runPkt('h0200, 'h19FC, 20, 48'hCAFE_0000_BABE, 0, 6, 50, 'h60, 1'b0);              // R10 follow-on
    runPkt('h19FC, 'h1B00, 30, 48'h7777_8888_9999, 0, 4, 9, 'h70, 1'b0);               // R5 header wrap, R9 high clamp

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule